// File: doc/BRIEF.md
# Video-RAM Block Copy Engine

This engine moves data from anywhere in the 64 KiB system address space into video RAM in blocks of sixteen bytes. Software loads a source address and a destination address into four byte registers. A write to the control register then launches a copy. The control register also reports progress: it shows the blocks still to go, whether a start was refused, and when the engine has finished.

There are two modes. In general mode the processor is held by the stall output, and the whole length is copied in one run that starts straight away. In blanking mode the engine arms itself. After that, each rising edge of the horizontal-blank input moves one 16-byte block, and the processor is held only for that block. Software can stop an armed blanking-mode copy between blocks. Memory is reached through a byte-wide read channel and a byte-wide write channel. Each channel uses a valid/ready handshake.

Top module: `vram_dma`

## Requirements
- R1: After reset, the control register (select 4) reads 0xFF, `cpu_stall` is low, and neither `rd_req_valid` nor `wr_valid` is asserted. Selects 0 to 3 read 0x00.
- R2: Register selects are 0 = source high byte, 1 = source low byte, 2 = destination high byte, 3 = destination low byte, 4 = control. When a start is accepted, the working source becomes {sel0,sel1} with bits 3:0 cleared. The working destination becomes ({sel2,sel3} AND 0x1FF0) OR 0x8000. Both values can be read back at once through selects 0 to 3.
- R3: A start whose aligned source lies in 0x8000–0x9FFF is refused. No memory access follows, and the control register reads the written value OR 0x80. Aligned sources of 0x7FF0 and 0xA000 are accepted.
- R4: An accepted start copies (bits 6:0 of the control write + 1) × 16 bytes. Each byte is read from the source address and then written, unchanged, to the destination address. Both addresses then step up by one. After the copy ends or is cancelled, selects 0 to 3 read back the addresses reached.
- R5: When bit 7 of the control write is 0 (general mode), `cpu_stall` rises in the cycle after the write is sampled. It stays high until the last byte has been written. While `rd_req_valid` or `wr_valid` is high, `cpu_stall` is high. When the copy ends, the control register reads 0xFF.
- R6: When bit 7 of the control write is 1 (blanking mode) and `lcd_on` is high, the control register reads the written value AND 0x7F, and nothing is copied yet. Each rising edge of `hblank` then copies one 16-byte block, with `cpu_stall` high only for that block. After each block, bits 6:0 count down by one. After the final block the register reads 0xFF.
- R7: A blanking-mode start while `lcd_on` is low is refused and copies nothing. The control register reads 0x80 OR ((written value + 1) AND 0x7F), so a write of 0xFF reads back 0x80.
- R8: While a blanking-mode copy is armed between blocks, a control write with bit 7 = 0 cancels it. The control register then reads 0x80 OR the remaining count, and later `hblank` edges copy nothing.
- R9: Register writes of any select are ignored while `cpu_stall` is high. Writes to selects 0 to 3 are also ignored while a copy is armed.
- R10: A read request holds its address, and a write holds its address and data, until accepted by ready. Only one byte is in flight at a time. The read response is taken on the first cycle in which `rd_rsp_valid` is high after the request was accepted.
- R11: An `hblank` level held high starts only one block. A rising edge while idle, or while a block is in progress, copies nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| lcd_on | input | 1 | Display enabled |
| hblank | input | 1 | Horizontal-blank level; its rising edge paces blanking mode |
| cpu_stall | output | 1 | Holds the processor while bytes are moving |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 16 | Read address |
| rd_rsp_valid | input | 1 | Read data valid; one pulse per accepted request, at least one cycle later |
| rd_rsp_data | input | 8 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |

## Verification
Some properties are checked by assertions on every cycle. Requests hold steady under back-pressure. A new block never starts while one is in progress. The stall covers every memory access. Writes are locked out during a stall. A newly accepted copy always has aligned addresses, with the destination in video RAM and the source outside it. The final block always leaves the control register at 0xFF.

Other behaviours are checked only by the bench scenarios. These include the exact readback codes for refused starts and cancelled copies, including the wrap of a 0xFF write. They also include the byte count and the address stream for each length, pacing by `hblank` edges, and the fact that a held level or an edge while idle does nothing.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [2:0]  SEL_SRC_HI = 3'd0;
  localparam logic [2:0]  SEL_SRC_LO = 3'd1;
  localparam logic [2:0]  SEL_DST_HI = 3'd2;
  localparam logic [2:0]  SEL_DST_LO = 3'd3;
  localparam logic [2:0]  SEL_CTRL   = 3'd4;
  localparam logic [15:0] VRAM_LO    = 16'h8000;
  localparam logic [15:0] VRAM_HI    = 16'h9FFF;
  localparam logic [15:0] VRAM_SPAN  = 16'h1FFF;
  localparam logic [7:0]  CTRL_IDLE  = 8'hFF;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WAIT, MV_WR} mv_state_t;
endpackage

// File: rtl/vdma_edge.sv
module vdma_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [15:0] src_addr,
  input  logic [15:0] dst_addr,
  output logic        busy,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [15:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [7:0]  rd_rsp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        byte_done,
  output logic        blk_done
);
  localparam int CW = $clog2(BLK_BYTES);
  localparam logic [CW-1:0] LAST = CW'(BLK_BYTES - 1);

  mv_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (go) begin
          state_q <= MV_RD;
          cnt_q   <= '0;
        end
        MV_RD:   if (rd_req_ready) state_q <= MV_WAIT;
        MV_WAIT: if (rd_rsp_valid) begin
          data_q  <= rd_rsp_data;
          state_q <= MV_WR;
        end
        MV_WR:   if (wr_ready) begin
          if (cnt_q == LAST) state_q <= MV_IDLE;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= MV_RD;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state_q != MV_IDLE);
    rd_req_valid = (state_q == MV_RD);
    wr_valid     = (state_q == MV_WR);
    rd_req_addr  = src_addr;
    wr_addr      = dst_addr;
    wr_data      = data_q;
    byte_done    = wr_valid && wr_ready;
    blk_done     = byte_done && (cnt_q == LAST);
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R10
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        lcd_on,
  input  logic        hbl_rise,
  input  logic        busy,
  input  logic        byte_done,
  input  logic        blk_done,
  output logic        go,
  output logic        stall,
  output logic [15:0] src_addr,
  output logic [15:0] dst_addr
);
  localparam logic [15:0] ALIGN    = ~16'(BLK_BYTES - 1);
  localparam logic [15:0] DST_MASK = VRAM_SPAN & ALIGN;

  logic [15:0] src_q, dst_q;
  logic [7:0]  ctrl_q;
  logic        active_q, hbl_q, go_q;

  logic [15:0] cand_src;
  logic        src_bad, wr_ok, ctrl_wr, cancel, lcd_rej, addr_wr;

  always_comb begin
    stall    = busy | go_q;
    cand_src = src_q & ALIGN;
    src_bad  = (cand_src >= VRAM_LO) && (cand_src <= VRAM_HI);
    wr_ok    = reg_we && !stall;
    ctrl_wr  = wr_ok && (reg_sel == SEL_CTRL);
    cancel   = ctrl_wr && active_q && hbl_q && !reg_wdata[7];
    lcd_rej  = reg_wdata[7] && !lcd_on;
    addr_wr  = wr_ok && !active_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      ctrl_q   <= CTRL_IDLE;
      active_q <= 1'b0;
      hbl_q    <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (byte_done) begin
        src_q <= src_q + 16'd1;
        dst_q <= dst_q + 16'd1;
      end
      if (blk_done) begin
        if (ctrl_q[6:0] == 7'd0) begin
          ctrl_q   <= CTRL_IDLE;
          active_q <= 1'b0;
        end else begin
          ctrl_q[6:0] <= ctrl_q[6:0] - 7'd1;
          if (!hbl_q) go_q <= 1'b1;
        end
      end
      if (hbl_rise && active_q && hbl_q && !stall) go_q <= 1'b1;
      if (addr_wr) begin
        case (reg_sel)
          SEL_SRC_HI: src_q[15:8] <= reg_wdata;
          SEL_SRC_LO: src_q[7:0]  <= reg_wdata;
          SEL_DST_HI: dst_q[15:8] <= reg_wdata;
          SEL_DST_LO: dst_q[7:0]  <= reg_wdata;
          default: ;
        endcase
      end
      if (cancel) begin
        active_q <= 1'b0;
        ctrl_q   <= {1'b1, ctrl_q[6:0]};
      end else if (ctrl_wr) begin
        if (src_bad) begin
          ctrl_q   <= reg_wdata | 8'h80;
          active_q <= 1'b0;
        end else if (lcd_rej) begin
          ctrl_q   <= {1'b1, reg_wdata[6:0] + 7'd1};
          active_q <= 1'b0;
        end else begin
          src_q    <= cand_src;
          dst_q    <= (dst_q & DST_MASK) | VRAM_LO;
          ctrl_q   <= {1'b0, reg_wdata[6:0]};
          active_q <= 1'b1;
          hbl_q    <= reg_wdata[7];
          go_q     <= !reg_wdata[7];
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_SRC_HI: reg_rdata = src_q[15:8];
      SEL_SRC_LO: reg_rdata = src_q[7:0];
      SEL_DST_HI: reg_rdata = dst_q[15:8];
      SEL_DST_LO: reg_rdata = dst_q[7:0];
      SEL_CTRL:   reg_rdata = ctrl_q;
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign go       = go_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;

  // R2
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> dst_q[15:13] == 3'b100 && dst_q[3:0] == 4'd0 && src_q[3:0] == 4'd0);
  // R3
  start_src_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !(src_q >= VRAM_LO && src_q <= VRAM_HI));
  // R5
  go_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> active_q);
  // R6
  last_block_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && ctrl_q[6:0] == 7'd0 |=> ctrl_q == CTRL_IDLE && !active_q);
  // R9
  stall_locks_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !byte_done |=> $stable(src_q) && $stable(dst_q) && $stable(ctrl_q));
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        lcd_on,
  input  logic        hblank,
  output logic        cpu_stall,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [15:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [7:0]  rd_rsp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data
);
  logic        hbl_rise, busy, byte_done, blk_done, go;
  logic [15:0] src_addr, dst_addr;

  vdma_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (hblank),
    .rise  (hbl_rise)
  );

  vdma_ctrl #(.BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lcd_on    (lcd_on),
    .hbl_rise  (hbl_rise),
    .busy      (busy),
    .byte_done (byte_done),
    .blk_done  (blk_done),
    .go        (go),
    .stall     (cpu_stall),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr)
  );

  vdma_mover #(.BLK_BYTES(BLK_BYTES)) u_mover (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .byte_done    (byte_done),
    .blk_done     (blk_done)
  );

  // R5
  access_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_valid) |-> cpu_stall);
endmodule

// File: tb/vram_dma_bench.sv
`timescale 1ns/1ps
module vram_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        lcd_on = 1'b1;
  logic        hblank = 1'b0;
  logic        cpu_stall;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [15:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = 8'd0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int errors = 0;
  int n_rd = 0;
  int cyc = 0;
  bit pend = 0;
  logic [15:0] pend_addr = 16'd0;
  logic [15:0] m_src, m_dst;
  logic [15:0] exp_rd[$];
  logic [23:0] exp_wr[$];

  always #2.5 clk = ~clk;

  vram_dma u_vram_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcd_on(lcd_on),
    .hblank(hblank), .cpu_stall(cpu_stall), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] mdat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model and per-clock comparison against the expected byte stream
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid = 1'b0;
      rd_req_ready = 1'b0;
      wr_ready     = 1'b0;
      pend         = 1'b0;
    end else begin
      cyc++;
      rd_rsp_valid = pend;
      rd_rsp_data  = mdat(pend_addr);
      pend         = 1'b0;
      rd_req_ready = (cyc % 4) != 3;
      wr_ready     = (cyc % 3) != 1;
      if ((rd_req_valid || wr_valid) && !cpu_stall)
        chk(1'b0, "R5", "access without stall", 0, 1);
      if (rd_req_valid && rd_req_ready) begin
        n_rd++;
        pend = 1'b1;
        pend_addr = rd_req_addr;
        if (exp_rd.size() == 0) chk(1'b0, "R10", "unexpected read", rd_req_addr, 0);
        else begin
          logic [15:0] e;
          e = exp_rd.pop_front();
          chk(rd_req_addr == e, "R4", "read address", rd_req_addr, e);
        end
      end
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) chk(1'b0, "R10", "unexpected write", wr_addr, 0);
        else begin
          logic [23:0] w;
          w = exp_wr.pop_front();
          chk({wr_addr, wr_data} == w, "R4", "write addr/data", {wr_addr, wr_data}, w);
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel;
    #0.5;
    chk(reg_rdata == exp, req, $sformatf("readback sel %0d", sel), reg_rdata, exp);
  endtask

  task automatic set_src(input logic [15:0] a);
    wr_reg(3'd0, a[15:8]); wr_reg(3'd1, a[7:0]);
  endtask

  task automatic set_dst(input logic [15:0] a);
    wr_reg(3'd2, a[15:8]); wr_reg(3'd3, a[7:0]);
  endtask

  task automatic push_blocks(input int nb);
    for (int i = 0; i < nb * 16; i++) begin
      exp_rd.push_back(m_src);
      exp_wr.push_back({m_dst, mdat(m_src)});
      m_src++;
      m_dst++;
    end
  endtask

  task automatic pulse_hbl(input int hold);
    @(negedge clk); hblank = 1'b1;
    repeat (hold) @(negedge clk);
    hblank = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    while ((cpu_stall || exp_wr.size() != 0) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(exp_wr.size() == 0 && exp_rd.size() == 0, req, "all expected bytes moved",
        exp_wr.size(), 0);
    @(negedge clk);
    chk(!cpu_stall, req, "stall released", cpu_stall, 0);
  endtask

  task automatic quiet(input int ncyc, input int rd_before, input string req);
    repeat (ncyc) @(negedge clk);
    chk(n_rd == rd_before, req, "no memory access", n_rd, rd_before);
    chk(!cpu_stall, req, "no stall", cpu_stall, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd4, 8'hFF, "R1");
    rd_chk(3'd0, 8'h00, "R1");
    rd_chk(3'd3, 8'h00, "R1");
    chk(!cpu_stall && !rd_req_valid && !wr_valid, "R1", "idle outputs",
        {cpu_stall, rd_req_valid, wr_valid}, 0);

    // General mode: 3 blocks, src 0x1234 -> 0x1230, dst 0xC5A7 -> 0x85A0
    set_src(16'h1234); set_dst(16'hC5A7);
    m_src = 16'h1230; m_dst = 16'h85A0;
    push_blocks(3);
    wr_reg(3'd4, 8'h02);
    chk(cpu_stall, "R5", "stall after general start", cpu_stall, 1);
    wr_reg(3'd0, 8'h77);          // R9: ignored while stalled
    wr_reg(3'd4, 8'h81);          // R9: ignored while stalled
    wait_idle("R5");
    rd_chk(3'd4, 8'hFF, "R5");
    rd_chk(3'd0, 8'h12, "R9");
    rd_chk(3'd1, 8'h60, "R4");
    rd_chk(3'd2, 8'h85, "R2");
    rd_chk(3'd3, 8'hD0, "R4");

    // R3 refused sources
    snap = n_rd;
    set_src(16'h8F00);
    wr_reg(3'd4, 8'h05);
    rd_chk(3'd4, 8'h85, "R3");
    set_src(16'h9FFF);
    wr_reg(3'd4, 8'h83);
    rd_chk(3'd4, 8'h83, "R3");
    quiet(20, snap, "R3");
    rd_chk(3'd0, 8'h9F, "R3");

    // R3 boundaries accepted
    set_src(16'h7FFF); set_dst(16'h0000);
    m_src = 16'h7FF0; m_dst = 16'h8000;
    push_blocks(1);
    wr_reg(3'd4, 8'h00);
    wait_idle("R3");
    rd_chk(3'd4, 8'hFF, "R3");
    set_src(16'hA000); set_dst(16'h1FFF);
    m_src = 16'hA000; m_dst = 16'h9FF0;
    push_blocks(1);
    wr_reg(3'd4, 8'h00);
    wait_idle("R3");
    rd_chk(3'd1, 8'h10, "R4");

    // R7 blanking mode with display off
    lcd_on = 1'b0;
    snap = n_rd;
    set_src(16'h4000); set_dst(16'h0100);
    wr_reg(3'd4, 8'h85);
    rd_chk(3'd4, 8'h86, "R7");
    wr_reg(3'd4, 8'hFF);
    rd_chk(3'd4, 8'h80, "R7");
    pulse_hbl(2);
    quiet(20, snap, "R7");
    lcd_on = 1'b1;

    // R6 blanking mode, 3 blocks, R2 alignment readback
    set_src(16'h2007); set_dst(16'h0805);
    wr_reg(3'd4, 8'h82);
    rd_chk(3'd4, 8'h02, "R6");
    rd_chk(3'd1, 8'h00, "R2");
    rd_chk(3'd2, 8'h88, "R2");
    rd_chk(3'd3, 8'h00, "R2");
    snap = n_rd;
    quiet(10, snap, "R6");
    m_src = 16'h2000; m_dst = 16'h8800;
    push_blocks(1);
    pulse_hbl(2);
    wait_idle("R6");
    rd_chk(3'd4, 8'h01, "R6");
    // R11: level held high gives one block only
    snap = n_rd;
    push_blocks(1);
    @(negedge clk); hblank = 1'b1;
    wait_idle("R11");
    repeat (40) @(negedge clk);
    chk(n_rd == snap + 16, "R11", "one block per held level", n_rd, snap + 16);
    hblank = 1'b0;
    rd_chk(3'd4, 8'h00, "R6");
    push_blocks(1);
    pulse_hbl(2);
    wait_idle("R6");
    rd_chk(3'd4, 8'hFF, "R6");
    snap = n_rd;
    pulse_hbl(2);
    quiet(20, snap, "R11");

    // R8 cancel between blocks
    set_src(16'h3000); set_dst(16'h1000);
    m_src = 16'h3000; m_dst = 16'h9000;
    wr_reg(3'd4, 8'h83);
    push_blocks(1);
    pulse_hbl(2);
    wait_idle("R8");
    rd_chk(3'd4, 8'h02, "R8");
    wr_reg(3'd2, 8'h00);          // R9: ignored while armed
    rd_chk(3'd2, 8'h90, "R9");
    wr_reg(3'd4, 8'h00);
    rd_chk(3'd4, 8'h82, "R8");
    snap = n_rd;
    pulse_hbl(2);
    quiet(30, snap, "R8");
    rd_chk(3'd0, 8'h30, "R8");
    rd_chk(3'd1, 8'h10, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule